// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write PHY management registers over a two-wire MDIO link. The host sees four 32-bit registers through a single-cycle register port. A configuration register holds the MDC divisor and an enable bit. A control register holds the PHY address, register address, opcode, a start bit and a ready flag. The other two registers hold the write data and the read data.

A transaction starts when the host writes the control register with the start bit set. The block then sends one 64-bit management frame on MDIO, MSB first. The frame is a 32-bit preamble of ones, the start pattern 01, the opcode, the two 5-bit addresses, a 2-bit turnaround and 16 data bits. MDC runs only while a frame is in flight. Its half-period is (divisor + 1) host cycles, so its frequency is fHOST / (2 × (divisor + 1)). Software chooses the divisor so that MDC stays at or below 2.5 MHz.

For a write, the data comes from the write-data register and the block drives turnaround as 10. For a read, the block releases the pin for the turnaround and data bits. It samples MDIO on each MDC rising edge and shifts the bits into the read-data register.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration register reads enable 0 with divisor 9, the control register reads only ready (bit 7) set, the read-data register reads 0, and MDC and the output enable are low.
- R2: While the enable bit (configuration bit 31) is 0, a control write with the start bit set starts nothing: ready stays 1, MDC stays low and MDIO is never driven.
- R3: During a frame, the MDC level j host cycles after acceptance is floor(j / (divisor+1)) mod 2, with the divisor in configuration bits [7:0]. MDC is low whenever no frame is in flight.
- R4: Ready drops in the cycle after a start is accepted. It returns to 1 exactly 128 × (divisor+1) host cycles after acceptance, on the falling MDC edge that follows the 64th rising edge.
- R5: A control write while ready is 0 is ignored. The frame in flight and its timing are unchanged, and the address and opcode fields read back their earlier values.
- R6: Frame bit b (b = 0..63) is presented from one host cycle after MDC rising edge b-1 (or from acceptance, for b = 0) until rising edge b. The bits are 32 ones, 01, the opcode (10 = read, 01 = write), the PHY address, then the register address, each MSB first.
- R7: In a write frame, bits 46 and 47 are driven as 1 then 0. Bits 48..63 carry the write-data register value captured at acceptance, MSB first. The output enable is high for all 64 bits.
- R8: In a read frame, the output enable is low from bit 46 through bit 63. The value on MDIO at rising edges 48..63 forms the read data MSB first. When ready returns, the read-data register holds it in bits [15:0], with bits [31:16] zero.
- R9: Register map by address: 0 = configuration (enable [31], divisor [7:0]); 1 = control (PHY address [28:24], register address [20:16], opcode [15:14], start [11], ready [7], with start reading 0); 2 = write data [15:0]; 3 = read data. Unlisted bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for reg_addr, same cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pin value |

## Verification
A wrong divisor counter or a missed MDC toggle appears on mdc within one half-period of the slip. The bench compares mdc every host cycle, so the first wrong level is caught at once. A slipped bit counter or shift register shows up as a wrong mdio_o or mdio_oe at the next bit boundary, and as a ready edge off by whole MDC periods. A bad read capture only appears in the read-data register after ready returns, so it is caught at the end of the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int AW         = 5;
    localparam int DW         = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam logic [CNT_W-1:0] TA_BIT   = CNT_W'(46);
    localparam logic [CNT_W-1:0] DATA_BIT = CNT_W'(48);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] END_BIT  = CNT_W'(FRAME_BITS);

    localparam logic [1:0] A_CFG   = 2'd0;
    localparam logic [1:0] A_CTRL  = 2'd1;
    localparam logic [1:0] A_WDATA = 2'd2;
    localparam logic [1:0] A_RDATA = 2'd3;

    localparam int EN_BIT   = 31;
    localparam int PHY_LSB  = 24;
    localparam int REG_LSB  = 16;
    localparam int OP_LSB   = 14;
    localparam int INIT_BIT = 11;
    localparam int RDY_BIT  = 7;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } mdio_op_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t s_d, s_q;
    logic    wrap;

    assign wrap = (s_q.cnt == div);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc    = s_q.mdc;
    assign rise_p = run && wrap && !s_q.mdc;
    assign fall_p = run && wrap && s_q.mdc;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  is_read,
    input  logic                  rise_p,
    input  logic                  fall_p,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [DW-1:0]         rdata
);
    typedef struct packed {
        logic                  busy;
        logic                  tail;
        logic                  seen;
        logic                  rd_mode;
        logic [CNT_W-1:0]      bitcnt;
        logic [FRAME_BITS-1:0] shreg;
        logic [DW-1:0]         rdata;
    } frm_st_t;

    frm_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.seen = rise_p;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy    = 1'b1;
                s_d.tail    = 1'b0;
                s_d.bitcnt  = '0;
                s_d.shreg   = frame;
                s_d.rd_mode = is_read;
            end
        end else begin
            // sample on the same host edge that raises MDC
            if (rise_p && s_q.rd_mode && s_q.bitcnt >= DATA_BIT && s_q.bitcnt <= LAST_BIT)
                s_d.rdata = {s_q.rdata[DW-2:0], mdio_i};
            if (rise_p && s_q.bitcnt == LAST_BIT)
                s_d.tail = 1'b1;
            // advance one host cycle after the rising edge
            if (s_q.seen && s_q.bitcnt != END_BIT) begin
                s_d.shreg  = {s_q.shreg[FRAME_BITS-2:0], 1'b1};
                s_d.bitcnt = s_q.bitcnt + 1'b1;
            end
            if (fall_p && s_q.tail) begin
                s_d.busy = 1'b0;
                s_d.tail = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign mdio_o  = s_q.shreg[FRAME_BITS-1];
    assign mdio_oe = s_q.busy && (s_q.bitcnt != END_BIT) &&
                     (!s_q.rd_mode || s_q.bitcnt < TA_BIT);
    assign rdata   = s_q.rdata;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [AW-1:0]    phy;
        logic [AW-1:0]    regad;
        logic [1:0]       op;
        logic [DW-1:0]    wdata;
    } regs_t;

    regs_t                 r_d, r_q;
    logic                  accept;
    logic                  busy;
    logic                  cfg_en;
    logic                  rise_p;
    logic                  fall_p;
    logic                  is_read;
    logic [FRAME_BITS-1:0] frame_word;
    logic [DW-1:0]         rd_word;
    logic [31:0]           ctrl_rd;
    logic                  unused_bits;

    assign unused_bits = ^{reg_wdata[30:29], reg_wdata[23:21]};

    always_comb begin
        r_d    = r_q;
        accept = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_CFG: begin
                    r_d.en  = reg_wdata[EN_BIT];
                    r_d.div = reg_wdata[DIV_W-1:0];
                end
                A_CTRL: begin
                    if (!busy) begin
                        r_d.phy   = reg_wdata[PHY_LSB +: AW];
                        r_d.regad = reg_wdata[REG_LSB +: AW];
                        r_d.op    = reg_wdata[OP_LSB +: 2];
                        accept    = reg_wdata[INIT_BIT] && r_q.en;
                    end
                end
                A_WDATA: r_d.wdata = reg_wdata[DW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.div <= DIV_W'(DIV_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_en     = r_q.en;
    assign is_read    = (reg_wdata[OP_LSB +: 2] == OP_RD);
    assign frame_word = {{PRE_BITS{1'b1}}, 2'b01, reg_wdata[OP_LSB +: 2],
                         reg_wdata[PHY_LSB +: AW], reg_wdata[REG_LSB +: AW],
                         2'b10, r_q.wdata};

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy && r_q.en),
        .div    (r_q.div),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .frame   (frame_word),
        .is_read (is_read),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rdata   (rd_word)
    );

    always_comb begin
        ctrl_rd                     = '0;
        ctrl_rd[PHY_LSB +: AW]      = r_q.phy;
        ctrl_rd[REG_LSB +: AW]      = r_q.regad;
        ctrl_rd[OP_LSB +: 2]        = r_q.op;
        ctrl_rd[RDY_BIT]            = !busy;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: begin
                reg_rdata[EN_BIT]      = r_q.en;
                reg_rdata[DIV_W-1:0]   = r_q.div;
            end
            A_CTRL:  reg_rdata = ctrl_rd;
            A_WDATA: reg_rdata[DW-1:0] = r_q.wdata;
            default: reg_rdata[DW-1:0] = rd_word;
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        start_req,
    input logic        busy,
    input logic        cfg_en,
    input logic        mdc,
    input logic        mdio_oe,
    input logic [14:0] ctrl_fields
);
    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !busy) |=> !busy);

    // R3
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R3
    mdc_rise_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(busy));

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_en && reg_wr && reg_addr == 2'd1 && start_req) |=> busy);

    // R6
    first_bit_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_en && reg_wr && reg_addr == 2'd1 && start_req) |=> mdio_oe);

    // R5
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 2'd1) |=> $stable(ctrl_fields));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .start_req   (reg_wdata[11]),
    .busy        (busy),
    .cfg_en      (cfg_en),
    .mdc         (mdc),
    .mdio_oe     (mdio_oe),
    .ctrl_fields (ctrl_rd[28:14])
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    always #4 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference state
    bit          m_busy;
    int          m_j;
    int          m_d;
    bit          m_en;
    bit          m_read;
    logic [63:0] m_frame;
    logic [15:0] m_wdata;
    logic [15:0] phy_val = 16'h0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_j <= 0; m_d <= 9; m_en <= 0; m_read <= 0;
            m_frame <= '0; m_wdata <= '0;
        end else begin
            if (m_busy) begin
                if (m_j + 1 == 128 * (m_d + 1)) m_busy <= 0;
                m_j <= m_j + 1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: begin m_en <= reg_wdata[31]; m_d <= int'(reg_wdata[7:0]); end
                    2'd1: if (!m_busy && reg_wdata[11] && m_en) begin
                        m_busy  <= 1;
                        m_j     <= 0;
                        m_read  <= (reg_wdata[15:14] == 2'b10);
                        m_frame <= {32'hFFFF_FFFF, 2'b01, reg_wdata[15:14],
                                    reg_wdata[28:24], reg_wdata[20:16], 2'b10, m_wdata};
                    end
                    2'd2: m_wdata <= reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            int b;
            bit e_mdc;
            bit e_oe;
            e_mdc = m_busy ? (((m_j / (m_d + 1)) % 2) == 1) : 1'b0;
            if (m_j == 0) b = 0;
            else b = ((m_j - 1) / (m_d + 1) + 1) / 2;
            if (b > 64) b = 64;
            e_oe = m_busy && b < 64 && (!m_read || b < 46);
            chk(mdc === e_mdc, "R3", "mdc level", 64'(mdc), 64'(e_mdc));
            chk(mdio_oe === e_oe, "R6", "mdio_oe", 64'(mdio_oe), 64'(e_oe));
            if (e_oe)
                chk(mdio_o === m_frame[63 - b], "R6", "mdio_o bit", 64'(mdio_o), 64'(m_frame[63 - b]));
            if (reg_addr == 2'd1)
                chk(reg_rdata[7] === !m_busy, "R4", "ready bit", 64'(reg_rdata[7]), 64'(!m_busy));
        end
    end

    // PHY model: records driven bits, returns read data
    int          rc = 0;
    bit          prev_mdc = 0;
    logic [63:0] cap = '0;
    always @(negedge clk) begin
        if (!m_busy) begin
            rc = 0;
            mdio_i <= 1'b1;
        end else if (mdc && !prev_mdc) begin
            cap[63 - rc] = mdio_o;
            rc++;
            if (rc >= 48 && rc <= 63) mdio_i <= phy_val[63 - rc];
            else mdio_i <= 1'b1;
        end
        prev_mdc = mdc;
    end

    int lowcnt = 0;
    always @(negedge clk) begin
        #1;
        if (rst_n && reg_addr == 2'd1 && !reg_rdata[7]) lowcnt++;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2;
        v = reg_rdata;
        reg_addr = 2'd1;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (m_busy && n < 60000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    function automatic logic [31:0] cw(input logic [4:0] p, input logic [4:0] r,
                                       input logic [1:0] o, input logic s);
        cw = '0;
        cw[28:24] = p; cw[20:16] = r; cw[15:14] = o; cw[11] = s;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] exp_frame;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd1; reg_wdata = '0; mdio_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk(v == 32'h0000_0009, "R1", "config after reset", 64'(v), 64'h9);
        rd(2'd1, v); chk(v == 32'h0000_0080, "R1", "control after reset", 64'(v), 64'h80);
        rd(2'd3, v); chk(v == 32'h0, "R1", "read data after reset", 64'(v), 64'h0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins after reset", 64'({mdc, mdio_oe}), 64'h0);

        // R2 start while disabled
        wr(2'd1, cw(5'h01, 5'h02, 2'b01, 1'b1));
        repeat (40) @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2", "pins while disabled", 64'({mdc, mdio_oe}), 64'h0);
        rd(2'd1, v);
        chk(v == (cw(5'h01, 5'h02, 2'b01, 1'b0) | 32'h80), "R2", "control while disabled", 64'(v),
            64'(cw(5'h01, 5'h02, 2'b01, 1'b0) | 32'h80));

        // R9 register readback
        wr(2'd0, 32'h8000_0001);
        rd(2'd0, v); chk(v == 32'h8000_0001, "R9", "config readback", 64'(v), 64'h8000_0001);
        wr(2'd2, 32'hFFFF_A5C3);
        rd(2'd2, v); chk(v == 32'h0000_A5C3, "R9", "write data readback", 64'(v), 64'hA5C3);

        // R7 write frame, divisor 1, with an ignored start mid-frame (R5)
        lowcnt = 0;
        wr(2'd1, cw(5'h11, 5'h05, 2'b01, 1'b1));
        repeat (50) @(negedge clk);
        wr(2'd1, cw(5'h1F, 5'h1F, 2'b10, 1'b1));
        wait_idle();
        chk(lowcnt == 256, "R4", "ready low cycles div 1", 64'(lowcnt), 64'd256);
        exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h05, 2'b10, 16'hA5C3};
        chk(cap == exp_frame, "R7", "write frame bits", cap, exp_frame);
        rd(2'd1, v);
        chk(v == (cw(5'h11, 5'h05, 2'b01, 1'b0) | 32'h80), "R5", "fields after busy write", 64'(v),
            64'(cw(5'h11, 5'h05, 2'b01, 1'b0) | 32'h80));

        // R8 read frame, divisor 0
        wr(2'd0, 32'h8000_0000);
        phy_val = 16'h3C96;
        lowcnt = 0;
        wr(2'd1, cw(5'h02, 5'h1F, 2'b10, 1'b1));
        wait_idle();
        chk(lowcnt == 128, "R4", "ready low cycles div 0", 64'(lowcnt), 64'd128);
        exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h02, 5'h1F, 18'h0};
        chk(cap[63:18] == exp_frame[63:18], "R6", "read header bits", 64'(cap[63:18]), 64'(exp_frame[63:18]));
        rd(2'd3, v); chk(v == 32'h0000_3C96, "R8", "read data div 0", 64'(v), 64'h3C96);

        // R8 read frame, divisor 3
        wr(2'd0, 32'h8000_0003);
        phy_val = 16'h8001;
        lowcnt = 0;
        wr(2'd1, cw(5'h0A, 5'h00, 2'b10, 1'b1));
        wait_idle();
        chk(lowcnt == 512, "R4", "ready low cycles div 3", 64'(lowcnt), 64'd512);
        rd(2'd3, v); chk(v == 32'h0000_8001, "R8", "read data div 3", 64'(v), 64'h8001);

        // R7 write frame, divisor 2
        wr(2'd0, 32'h8000_0002);
        wr(2'd2, 32'h0000_FFFF);
        lowcnt = 0;
        wr(2'd1, cw(5'h00, 5'h10, 2'b01, 1'b1));
        wait_idle();
        chk(lowcnt == 384, "R4", "ready low cycles div 2", 64'(lowcnt), 64'd384);
        exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h00, 5'h10, 2'b10, 16'hFFFF};
        chk(cap == exp_frame, "R7", "write frame bits div 2", cap, exp_frame);
        rd(2'd3, v); chk(v == 32'h0000_8001, "R8", "read data kept after write", 64'(v), 64'h8001);

        summary();
        $finish;
    end
endmodule